// File: doc/BRIEF.md
# Bus-Master Disk DMA Channel Registers

This block holds the host-visible control registers of a bus-master disk DMA engine with several channels. Each channel owns an 8-byte slice of a small I/O window. Channel i starts at byte offset 8*i, so the default two channels fill 16 bytes. Within a slice there are four kinds of register:

- a command byte, which starts and stops transfers and holds the transfer direction;
- a status byte, which mixes engine-owned, write-one-to-clear and plain read/write bits;
- two optional vendor bytes;
- a 32-bit descriptor-table pointer.

Host software reaches the window through a simple I/O port that takes byte, 16-bit and 32-bit accesses. For each channel, the block drives the following towards the engine:

- a one-cycle start pulse;
- a one-cycle cancel pulse;
- the direction bit;
- the current descriptor pointer;
- the status byte.

The engine reports back through three per-channel inputs: clear the active flag, set the error flag, and set the interrupt flag. Descriptor fetching, data movement and the drive protocol sit outside this block.

The register port has no back-pressure and no valid/ready pair. A write is taken at the clock edge where `io_wr` is high. Reads have no side effects, so `io_rdata` is a combinational view of the addressed bytes. A write shows in `io_rdata` and in the outputs from the cycle after its edge.

Top module: `busdma_regs`

## Requirements
- R1: After reset, every command, status and pointer register reads 0, every current pointer is 0, and no start or cancel pulse is driven. When vendor bytes are present they also read 0.
- R2: A write that covers byte offset 0 of a slice keeps only bit 0 (start) and bit 3 (direction) of that byte, so it reads back as data AND 0x09. `dma_dir` reflects bit 3.
- R3: A command write with bit 0 set, taken while status bit 0 (active) is 0, sets active and drives `dma_start` for exactly the one cycle after the write edge. If active is already 1, no start pulse is produced.
- R4: A command write with bit 0 clear drives `dma_cancel` for the one cycle after the write edge. Active is 0 one cycle after that, unless a start taken in the cancel cycle sets it again. Start and cancel are never driven together.
- R5: A write that covers byte offset 2 (status) does the following. Bits 5 and 6 take the written value. Bit 0 keeps its value. Bits 1 and 2 clear where the written bit is 1 and otherwise hold. Bits 3, 4 and 7 always read 0.
- R6: `eng_clr_active` clears status bit 0. `eng_set_err` sets bit 1 and `eng_set_irq` sets bit 2. Each takes effect at the next edge. A set wins over a write-one-to-clear taken at the same edge, and a start wins over a clear of active at the same edge.
- R7: Offsets 4..7 form the 32-bit pointer, with offset 4 holding the least significant byte. Byte and 16-bit writes replace only the addressed lanes. After any pointer write, bits 1:0 are 0.
- R8: The current pointer output `dma_cur_addr` takes the new pointer value at the same edge as any pointer write.
- R9: A read of size 1, 2 or 4 bytes returns the addressed bytes shifted down to bit 0, lowest offset in the low byte, with the unused upper bits 0.
- R10: With vendor bytes absent, offsets 1 and 3 read 0xFF and writes to them are ignored. With vendor bytes present, both are per-channel bytes that are fully writable.
- R11: Channel i occupies offsets 8*i to 8*i+7. A write to one channel leaves every register and pulse of the other channels unchanged.
- R12: Size code 0 means 1 byte, 1 means 2 bytes, 2 means 4 bytes, and 3 is invalid. An access that is not naturally aligned, that uses size code 3, or that addresses a channel past the last one is dropped: a write changes nothing and a read returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_wr | input | 1 | Write strobe, taken at the rising edge |
| io_addr | input | CH_W+3 (4) | Byte address within the window |
| io_size | input | 2 | Access size: 0 byte, 1 half, 2 word, 3 invalid |
| io_wdata | input | 32 | Write data, low byte at the addressed offset |
| io_rdata | output | 32 | Read data for the addressed bytes |
| eng_clr_active | input | NUM_CH | Engine clears the active bit |
| eng_set_err | input | NUM_CH | Engine sets the error bit |
| eng_set_irq | input | NUM_CH | Engine sets the interrupt bit |
| dma_start | output | NUM_CH | One-cycle transfer start pulse |
| dma_cancel | output | NUM_CH | One-cycle transfer cancel pulse |
| dma_dir | output | NUM_CH | Direction bit of the command register |
| dma_cur_addr | output | 32*NUM_CH | Current descriptor pointer per channel |
| dma_status | output | 8*NUM_CH | Status byte per channel |

## Verification
The bench sweeps all 256 command values and all 256 status values, and checks after each write:

- **Command mask.** A design that stored more of the command byte would show extra bits in readback.
- **Start on active channel.** A design that started a transfer on a channel already active would issue a second start pulse.
- **Status bits.** A design that cleared bits 5 and 6 the same way as bits 1 and 2, or that let a write change the active bit, would read back wrong status values.

The pointer is written at every size and aligned offset, and a model in the bench tracks it:

- **Partial writes.** Lane merges that clobber neighbouring bytes, or a missed forcing of bits 1:0 to zero, would show in the readback.
- **Reads.** Every read size is checked at every aligned offset.

Directed cases cover the remaining corners:

- **Cancel.** The active bit must clear one cycle after the cancel pulse.
- **Engine sets.** A set must win over a write-one-to-clear taken at the same edge.
- **Channel isolation.** A write must not leak into another channel.
- **Dropped accesses.** Misaligned or invalid accesses must have no effect.
- **Vendor bytes.** A second instance without vendor bytes must read 0xFF at offsets 1 and 3 and ignore writes there.

// File: rtl/busdma_pkg.sv
package busdma_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  localparam int SLICE_BYTES = 8;
  localparam int SLICE_BITS  = SLICE_BYTES * 8;

  localparam int OFS_CMD   = 0;
  localparam int OFS_VND_A = 1;
  localparam int OFS_STS   = 2;
  localparam int OFS_VND_B = 3;
  localparam int OFS_PTR   = 4;

  localparam logic [7:0] CMD_KEEP_MASK = 8'h09;
  localparam int CMD_BIT_GO  = 0;
  localparam int CMD_BIT_DIR = 3;

  localparam int STS_BIT_ACTIVE = 0;
  localparam int STS_BIT_ERR    = 1;
  localparam int STS_BIT_IRQ    = 2;
  localparam logic [7:0] STS_RW_MASK  = 8'h60;

  localparam logic [7:0] VND_ABSENT = 8'hFF;

  function automatic logic [7:0] size_lane_mask(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: return 8'h01;
      SZ_HALF: return 8'h03;
      SZ_WORD: return 8'h0F;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/busdma_decode.sv
module busdma_decode
  import busdma_pkg::*;
#(
  parameter int NUM_CH = 2,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int ADDR_W = CH_W + 3
) (
  input  logic              io_wr,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [1:0]        io_size,
  input  logic [31:0]       io_wdata,
  output logic              acc_ok,
  output logic [CH_W-1:0]   acc_ch,
  output logic [2:0]        acc_ofs,
  output logic [7:0]        byte_en,
  output logic [63:0]       lane_data,
  output logic [NUM_CH-1:0] ch_wr
);

  logic align_ok;
  logic ch_in_range;

  always_comb begin
    acc_ofs = io_addr[2:0];
    acc_ch  = io_addr[ADDR_W-1:3];
    case (io_size)
      SZ_BYTE: align_ok = 1'b1;
      SZ_HALF: align_ok = ~acc_ofs[0];
      SZ_WORD: align_ok = (acc_ofs[1:0] == 2'b00);
      default: align_ok = 1'b0;
    endcase
    ch_in_range = (32'(acc_ch) < NUM_CH);
    acc_ok      = align_ok && ch_in_range;
    byte_en     = acc_ok ? (size_lane_mask(io_size) << acc_ofs) : 8'h00;
    lane_data   = {32'd0, io_wdata} << {acc_ofs, 3'b000};
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_sel
    assign ch_wr[c] = io_wr && acc_ok && (acc_ch == CH_W'(c));
  end

endmodule

// File: rtl/busdma_chan.sv
module busdma_chan
  import busdma_pkg::*;
#(
  parameter bit HAS_VENDOR = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [7:0]  byte_en,
  input  logic [63:0] lane_data,
  input  logic        eng_clr_active,
  input  logic        eng_set_err,
  input  logic        eng_set_irq,
  output logic [63:0] window,
  output logic        start_pulse,
  output logic        cancel_pulse,
  output logic        dir,
  output logic [31:0] cur_addr,
  output logic [7:0]  status
);

  logic [7:0]  cmd_q, sts_q, sts_d, cmd_d;
  logic [31:0] ptr_q, ptr_d;
  logic        start_q, cancel_q;
  logic [7:0]  vnd_a_rd, vnd_b_rd;

  logic [7:0] w_cmd, w_sts;
  logic       cmd_wr, sts_wr, ptr_wr;
  logic       start_req, cancel_req;

  assign w_cmd  = lane_data[8*OFS_CMD +: 8];
  assign w_sts  = lane_data[8*OFS_STS +: 8];
  assign cmd_wr = wr_en && byte_en[OFS_CMD];
  assign sts_wr = wr_en && byte_en[OFS_STS];
  assign ptr_wr = wr_en && (|byte_en[OFS_PTR +: 4]);

  assign start_req  = cmd_wr && w_cmd[CMD_BIT_GO] && !sts_q[STS_BIT_ACTIVE];
  assign cancel_req = cmd_wr && !w_cmd[CMD_BIT_GO];

  always_comb begin
    cmd_d = cmd_wr ? (w_cmd & CMD_KEEP_MASK) : cmd_q;
  end

  // status next state: clear-then-set ordering for every bit
  always_comb begin
    sts_d = sts_q;
    if (cancel_q || eng_clr_active) sts_d[STS_BIT_ACTIVE] = 1'b0;
    if (start_req)                  sts_d[STS_BIT_ACTIVE] = 1'b1;
    if (sts_wr) begin
      sts_d[STS_BIT_ERR] = sts_q[STS_BIT_ERR] & ~w_sts[STS_BIT_ERR];
      sts_d[STS_BIT_IRQ] = sts_q[STS_BIT_IRQ] & ~w_sts[STS_BIT_IRQ];
      sts_d[6:5]         = w_sts[6:5];
    end
    if (eng_set_err) sts_d[STS_BIT_ERR] = 1'b1;
    if (eng_set_irq) sts_d[STS_BIT_IRQ] = 1'b1;
    sts_d[7]   = 1'b0;
    sts_d[4:3] = 2'b00;
  end

  for (genvar b = 0; b < 4; b++) begin : g_ptr_lane
    if (b == 0) begin : g_low
      assign ptr_d[7:0] = byte_en[OFS_PTR] ?
                          {lane_data[8*OFS_PTR + 2 +: 6], 2'b00} :
                          {ptr_q[7:2], 2'b00};
    end else begin : g_upper
      assign ptr_d[8*b +: 8] = byte_en[OFS_PTR + b] ?
                               lane_data[8*(OFS_PTR + b) +: 8] :
                               ptr_q[8*b +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q    <= '0;
      sts_q    <= '0;
      ptr_q    <= '0;
      cur_addr <= '0;
      start_q  <= 1'b0;
      cancel_q <= 1'b0;
    end else begin
      cmd_q    <= cmd_d;
      sts_q    <= sts_d;
      start_q  <= start_req;
      cancel_q <= cancel_req;
      if (ptr_wr) begin
        ptr_q    <= ptr_d;
        cur_addr <= ptr_d;
      end
    end
  end

  if (HAS_VENDOR) begin : g_vendor
    logic [7:0] vnd_a_q, vnd_b_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vnd_a_q <= '0;
        vnd_b_q <= '0;
      end else begin
        if (wr_en && byte_en[OFS_VND_A]) vnd_a_q <= lane_data[8*OFS_VND_A +: 8];
        if (wr_en && byte_en[OFS_VND_B]) vnd_b_q <= lane_data[8*OFS_VND_B +: 8];
      end
    end
    assign vnd_a_rd = vnd_a_q;
    assign vnd_b_rd = vnd_b_q;
  end else begin : g_no_vendor
    assign vnd_a_rd = VND_ABSENT;
    assign vnd_b_rd = VND_ABSENT;
  end

  assign window       = {ptr_q, vnd_b_rd, sts_q, vnd_a_rd, cmd_q};
  assign start_pulse  = start_q;
  assign cancel_pulse = cancel_q;
  assign dir          = cmd_q[CMD_BIT_DIR];
  assign status       = sts_q;

endmodule

// File: rtl/busdma_read_mux.sv
module busdma_read_mux
  import busdma_pkg::*;
#(
  parameter int NUM_CH = 2,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic [NUM_CH*SLICE_BITS-1:0] win_flat,
  input  logic                         acc_ok,
  input  logic [CH_W-1:0]              acc_ch,
  input  logic [2:0]                   acc_ofs,
  input  logic [1:0]                   io_size,
  output logic [31:0]                  rdata
);

  logic [SLICE_BITS-1:0] sel_win, shifted;
  logic [31:0]           size_mask;

  always_comb begin
    sel_win = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (acc_ch == CH_W'(c)) sel_win = win_flat[SLICE_BITS*c +: SLICE_BITS];
    end
    shifted = sel_win >> {acc_ofs, 3'b000};
    case (io_size)
      SZ_BYTE: size_mask = 32'h0000_00FF;
      SZ_HALF: size_mask = 32'h0000_FFFF;
      SZ_WORD: size_mask = 32'hFFFF_FFFF;
      default: size_mask = 32'h0;
    endcase
    rdata = acc_ok ? (shifted[31:0] & size_mask) : 32'h0;
  end

endmodule

// File: rtl/busdma_regs.sv
module busdma_regs
  import busdma_pkg::*;
#(
  parameter int NUM_CH     = 2,
  parameter bit HAS_VENDOR = 1'b1,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int ADDR_W = CH_W + 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 io_wr,
  input  logic [ADDR_W-1:0]    io_addr,
  input  logic [1:0]           io_size,
  input  logic [31:0]          io_wdata,
  output logic [31:0]          io_rdata,
  input  logic [NUM_CH-1:0]    eng_clr_active,
  input  logic [NUM_CH-1:0]    eng_set_err,
  input  logic [NUM_CH-1:0]    eng_set_irq,
  output logic [NUM_CH-1:0]    dma_start,
  output logic [NUM_CH-1:0]    dma_cancel,
  output logic [NUM_CH-1:0]    dma_dir,
  output logic [NUM_CH*32-1:0] dma_cur_addr,
  output logic [NUM_CH*8-1:0]  dma_status
);

  logic                         acc_ok;
  logic [CH_W-1:0]              acc_ch;
  logic [2:0]                   acc_ofs;
  logic [7:0]                   byte_en;
  logic [63:0]                  lane_data;
  logic [NUM_CH-1:0]            ch_wr;
  logic [NUM_CH*SLICE_BITS-1:0] win_flat;

  busdma_decode #(.NUM_CH(NUM_CH)) u_decode (
    .io_wr     (io_wr),
    .io_addr   (io_addr),
    .io_size   (io_size),
    .io_wdata  (io_wdata),
    .acc_ok    (acc_ok),
    .acc_ch    (acc_ch),
    .acc_ofs   (acc_ofs),
    .byte_en   (byte_en),
    .lane_data (lane_data),
    .ch_wr     (ch_wr)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    busdma_chan #(.HAS_VENDOR(HAS_VENDOR)) u_chan (
      .clk            (clk),
      .rst_n          (rst_n),
      .wr_en          (ch_wr[c]),
      .byte_en        (byte_en),
      .lane_data      (lane_data),
      .eng_clr_active (eng_clr_active[c]),
      .eng_set_err    (eng_set_err[c]),
      .eng_set_irq    (eng_set_irq[c]),
      .window         (win_flat[SLICE_BITS*c +: SLICE_BITS]),
      .start_pulse    (dma_start[c]),
      .cancel_pulse   (dma_cancel[c]),
      .dir            (dma_dir[c]),
      .cur_addr       (dma_cur_addr[32*c +: 32]),
      .status         (dma_status[8*c +: 8])
    );
  end

  busdma_read_mux #(.NUM_CH(NUM_CH)) u_rmux (
    .win_flat (win_flat),
    .acc_ok   (acc_ok),
    .acc_ch   (acc_ch),
    .acc_ofs  (acc_ofs),
    .io_size  (io_size),
    .rdata    (io_rdata)
  );

endmodule

// File: rtl/busdma_regs_chk.sv
module busdma_regs_chk #(
  parameter int NUM_CH = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_CH-1:0]    eng_set_err,
  input logic [NUM_CH-1:0]    eng_set_irq,
  input logic [NUM_CH-1:0]    dma_start,
  input logic [NUM_CH-1:0]    dma_cancel,
  input logic [NUM_CH*32-1:0] dma_cur_addr,
  input logic [NUM_CH*8-1:0]  dma_status
);

  logic past_ok;
  always_ff @(posedge clk) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ast
    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      dma_start[c] |=> !dma_start[c]); // R3
    AST_START_SETS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      dma_start[c] |-> dma_status[8*c]); // R3
    AST_CANCEL_DROPS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      dma_cancel[c] |=> (!dma_status[8*c] || dma_start[c])); // R4
    AST_START_CANCEL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(dma_start[c] && dma_cancel[c])); // R4
    AST_STS_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_status[8*c+3] == 1'b0) && (dma_status[8*c+4] == 1'b0) && (dma_status[8*c+7] == 1'b0)); // R5
    AST_ERR_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(eng_set_err[c])) |-> dma_status[8*c+1]); // R6
    AST_IRQ_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(eng_set_irq[c])) |-> dma_status[8*c+2]); // R6
    AST_PTR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      dma_cur_addr[32*c +: 2] == 2'b00); // R7
  end

endmodule

bind busdma_regs busdma_regs_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .eng_set_err  (eng_set_err),
  .eng_set_irq  (eng_set_irq),
  .dma_start    (dma_start),
  .dma_cancel   (dma_cancel),
  .dma_cur_addr (dma_cur_addr),
  .dma_status   (dma_status)
);

// File: tb/busdma_regs_tb.sv
`timescale 1ns/1ps
module busdma_regs_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_wr = 1'b0;
  logic [3:0]  io_addr = '0;
  logic [1:0]  io_size = '0;
  logic [31:0] io_wdata = '0;
  logic [31:0] rdata, rdata_nv;
  logic [1:0]  eng_clr = '0, eng_err = '0, eng_irq = '0;
  logic [1:0]  start, cancel, dir, start_nv, cancel_nv, dir_nv;
  logic [63:0] cur, cur_nv;
  logic [15:0] sts, sts_nv;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  busdma_regs #(.NUM_CH(2), .HAS_VENDOR(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr), .io_size(io_size),
    .io_wdata(io_wdata), .io_rdata(rdata), .eng_clr_active(eng_clr),
    .eng_set_err(eng_err), .eng_set_irq(eng_irq), .dma_start(start),
    .dma_cancel(cancel), .dma_dir(dir), .dma_cur_addr(cur), .dma_status(sts));

  busdma_regs #(.NUM_CH(2), .HAS_VENDOR(1'b0)) u_dut_nv (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr), .io_size(io_size),
    .io_wdata(io_wdata), .io_rdata(rdata_nv), .eng_clr_active(eng_clr),
    .eng_set_err(eng_err), .eng_set_irq(eng_irq), .dma_start(start_nv),
    .dma_cancel(cancel_nv), .dma_dir(dir_nv), .dma_cur_addr(cur_nv), .dma_status(sts_nv));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act %h exp %h", req, act, exp);
    end
  endtask

  task automatic io_write(input logic [3:0] a, input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    io_wr = 1'b1; io_addr = a; io_size = s; io_wdata = d;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic io_read(input logic [3:0] a, input logic [1:0] s, output logic [31:0] d);
    io_addr = a; io_size = s;
    #1;
    d = rdata;
  endtask

  task automatic eng_pulse(input logic [1:0] clr, input logic [1:0] err, input logic [1:0] irq);
    @(negedge clk);
    eng_clr = clr; eng_err = err; eng_irq = irq;
    @(negedge clk);
    eng_clr = '0; eng_err = '0; eng_irq = '0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] rd, m, d, exp;
    logic [7:0]  e8;
    int k;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    io_read(4'd0, 2'd2, rd);  chk(rd == 0, "R1 ch0 word0", rd, 0);
    io_read(4'd4, 2'd2, rd);  chk(rd == 0, "R1 ch0 ptr", rd, 0);
    io_read(4'd8, 2'd2, rd);  chk(rd == 0, "R1 ch1 word0", rd, 0);
    io_read(4'd12, 2'd2, rd); chk(rd == 0, "R1 ch1 ptr", rd, 0);
    chk(cur == 0 && sts == 0, "R1 outputs", {cur[31:0], 16'h0, sts}, 0);
    chk(start == 0 && cancel == 0, "R1 pulses", {start, cancel}, 0);
    io_addr = 4'd0; io_size = 2'd2; #1;
    chk(rdata_nv == 32'hFF00FF00, "R1 R10 no-vendor word0", rdata_nv, 32'hFF00FF00);

    // R2 R3 R4: sweep of all command values on channel 0
    for (int v = 0; v < 256; v++) begin
      io_write(4'd0, 2'd0, 32'h0);
      io_write(4'd0, 2'd0, 32'(v));
      chk(start[0] == v[0], "R3 start pulse", start, v[0]);
      chk(cancel[0] == !v[0], "R4 cancel pulse", cancel, !v[0]);
      chk(start[1] == 0 && cancel[1] == 0, "R11 ch1 quiet", {start, cancel}, 0);
      io_read(4'd0, 2'd0, rd);
      chk(rd == (32'(v) & 32'h09), "R2 cmd mask", rd, 32'(v) & 32'h09);
      chk(dir[0] == v[3], "R2 dir", dir, v[3]);
      chk(sts[0] == v[0], "R3 active", sts[0], v[0]);
      if (v[0]) begin
        io_write(4'd0, 2'd0, 32'(v));
        chk(start[0] == 0, "R3 no restart while active", start, 0);
      end
    end

    // R4 cancel timing
    io_write(4'd0, 2'd0, 32'h1);
    io_write(4'd0, 2'd0, 32'h0);
    chk(cancel[0] == 1 && sts[0] == 1, "R4 cancel cycle", {cancel, sts[7:0]}, 64'h1_01);
    @(negedge clk);
    chk(cancel[0] == 0 && sts[0] == 0, "R4 active cleared", {cancel, sts[7:0]}, 0);

    // R5 status sweep on channel 1 (offset 10)
    for (int v = 0; v < 256; v++) begin
      io_write(4'd8, 2'd0, 32'h1);
      eng_pulse(2'b00, 2'b10, 2'b10);
      io_write(4'd10, 2'd0, 32'(v));
      e8 = 8'h01 | (8'(v) & 8'h60) | (8'h06 & ~8'(v));
      io_read(4'd10, 2'd0, rd);
      chk(rd == 32'(e8), "R5 status write", rd, e8);
      chk(sts[15:8] == e8, "R5 status port", sts[15:8], e8);
      chk(sts[7:0] == 8'h00, "R11 ch0 status untouched", sts[7:0], 0);
    end

    // R6 engine inputs
    io_write(4'd0, 2'd0, 32'h1);
    eng_pulse(2'b01, 2'b00, 2'b00);
    chk(sts[0] == 0, "R6 engine clears active", sts[7:0], 0);
    eng_pulse(2'b00, 2'b01, 2'b01);
    chk(sts[2:1] == 2'b11, "R6 engine sets err irq", sts[7:0], 8'h06);
    @(negedge clk);
    io_wr = 1'b1; io_addr = 4'd2; io_size = 2'd0; io_wdata = 32'h06; eng_err = 2'b01;
    @(negedge clk);
    io_wr = 1'b0; eng_err = 2'b00;
    chk(sts[7:0] == 8'h02, "R6 set wins over w1c", sts[7:0], 8'h02);

    // R7 R8 R9 pointer sweep on channel 0 with model
    m = 0; k = 0;
    for (int s = 0; s < 3; s++) begin
      for (int rep = 0; rep < 6; rep++) begin
        for (int o = 4; o < 8; o += (1 << s)) begin
          k++;
          d = (32'h9E3779B9 * 32'(k)) ^ 32'(k * 7);
          for (int b = 0; b < (1 << s); b++) m[8*(o-4+b) +: 8] = d[8*b +: 8];
          m[1:0] = 2'b00;
          io_write(4'(o), 2'(s), d);
          io_read(4'd4, 2'd2, rd);
          chk(rd == m, "R7 pointer lanes", rd, m);
          chk(cur[31:0] == m, "R8 current pointer", cur[31:0], m);
          for (int rs = 0; rs < 3; rs++) begin
            for (int ro = 4; ro < 8; ro += (1 << rs)) begin
              exp = (m >> (8 * (ro - 4))) & ((rs == 2) ? 32'hFFFFFFFF : ((32'h1 << (8 << rs)) - 1));
              io_read(4'(ro), 2'(rs), rd);
              chk(rd == exp, "R9 read lane", rd, exp);
            end
          end
        end
      end
    end

    // R11 channel isolation
    io_write(4'd12, 2'd2, 32'h12345677);
    io_read(4'd12, 2'd2, rd);
    chk(rd == 32'h12345674, "R11 ch1 pointer", rd, 32'h12345674);
    io_read(4'd4, 2'd2, rd);
    chk(rd == m && cur[31:0] == m, "R11 ch0 pointer kept", rd, m);
    io_write(4'd8, 2'd0, 32'h0);
    io_write(4'd0, 2'd0, 32'h0);
    io_write(4'd8, 2'd0, 32'h1);
    chk(start == 2'b10, "R11 start only ch1", start, 2'b10);

    // R12 dropped accesses
    io_write(4'd6, 2'd2, 32'hFFFFFFFF);
    io_write(4'd5, 2'd1, 32'hFFFFFFFF);
    io_write(4'd4, 2'd3, 32'hFFFFFFFF);
    io_read(4'd4, 2'd2, rd);
    chk(rd == m, "R12 misaligned write ignored", rd, m);
    io_write(4'd1, 2'd2, 32'hFFFFFFFF);
    chk(start[0] == 0, "R12 misaligned no start", start, 0);
    io_read(4'd5, 2'd1, rd);
    chk(rd == 0, "R12 misaligned read zero", rd, 0);
    io_read(4'd4, 2'd3, rd);
    chk(rd == 0, "R12 invalid size read zero", rd, 0);

    // R10 vendor bytes
    io_write(4'd3, 2'd0, 32'hA5);
    io_write(4'd1, 2'd0, 32'h3C);
    io_write(4'd11, 2'd0, 32'h5A);
    io_read(4'd3, 2'd0, rd);  chk(rd == 32'hA5, "R10 vendor b", rd, 32'hA5);
    io_read(4'd1, 2'd0, rd);  chk(rd == 32'h3C, "R10 vendor a", rd, 32'h3C);
    io_read(4'd11, 2'd0, rd); chk(rd == 32'h5A, "R10 ch1 vendor b", rd, 32'h5A);
    io_read(4'd9, 2'd0, rd);  chk(rd == 32'h00, "R10 ch1 vendor a", rd, 0);
    io_addr = 4'd3; io_size = 2'd0; #1;
    chk(rdata_nv == 32'hFF, "R10 absent b reads FF", rdata_nv, 32'hFF);
    io_addr = 4'd1; #1;
    chk(rdata_nv == 32'hFF, "R10 absent a reads FF", rdata_nv, 32'hFF);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule